// File: doc/BRIEF.md
# Receive Flow-Delay RTS Controller

This block decides the level of the request-to-send pin of a serial port from how full its receive FIFO is. Software programs a 6-bit hold threshold. When the FIFO level reaches that threshold, an internal hold flag sets. The flag stays set until the level has drained at least four entries below the threshold. This gap gives a hysteresis band, so the pin does not toggle on every byte.

In hardware flow-control mode the pin is deasserted while the hold flag is set, which tells the far end to pause. With flow control off, the pin simply reflects a software request bit. The hold flag is also presented as a plain status output and raises no interrupt. A threshold below four switches the hold mechanism off entirely. All outputs are registered and change on the clock edge that follows the inputs that cause them.

Top module: `rx_flow_rts_ctrl`

## Requirements
- R1: With a threshold of 4 or more, a FIFO level greater than or equal to the threshold sets `hold_active` at the next clock edge.
- R2: While `rst_n` is low at a clock edge, `hold_active` becomes 0 and `rts_n` becomes 1 (pin deasserted).
- R3: With `fc_mode` = 1, `rts_n` equals `hold_active` after each clock edge: 1 (deasserted) while holding, 0 (asserted) otherwise.
- R4: Once `hold_active` is set, it stays set while the level is above threshold minus 4. It clears at the first edge where the level is at or below threshold minus 4.
- R5: A threshold value of 0 to 3 clears `hold_active` at the next edge and keeps it clear, whatever the level.
- R6: With `fc_mode` = 0, `rts_n` takes the inverse of `sw_rts` at the next edge (`sw_rts` = 1 drives the pin low). `hold_active` keeps tracking the level meanwhile.
- R7: While `hold_active` is clear, a level below the threshold, including one inside the hysteresis band, leaves it clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_level | input | LVL_W (7) | Current receive FIFO fill level |
| hold_thr | input | 6 | Flow-delay threshold; values below 4 disable holding |
| fc_mode | input | 1 | 1 = hardware flow control drives the pin |
| sw_rts | input | 1 | Software request bit, used when `fc_mode` is 0 |
| rts_n | output | 1 | Request-to-send pin, active low |
| hold_active | output | 1 | Flow-delay trigger status |

## Verification
The assertions assume that `rx_level`, `hold_thr`, `fc_mode` and `sw_rts` are stable and known around each rising edge. They also assume that the level never exceeds what `LVL_W` bits can hold. The bench meets both assumptions by changing every input half a period away from the sampling edge, and by keeping levels between 0 and 64. Threshold changes are applied while the hold flag is set, which exercises the disable path without violating those assumptions.

// File: rtl/rts_pkg.sv
// Package rts_pkg
// Shared constants for the flow-delay RTS controller.
// Assumes: threshold field width and hysteresis gap are fixed by the port spec.
package rts_pkg;
    localparam int THR_W   = 6;   // width of the hold threshold field
    localparam int HYST    = 4;   // drain distance before the hold releases
    localparam int MIN_THR = 4;   // smallest threshold that enables holding

    // Result of decoding the threshold against the level
    typedef struct packed {
        logic enabled;   // threshold large enough to activate holding
        logic reach;     // level at or above threshold
        logic drained;   // level at or below threshold minus HYST
    } hold_cmp_t;
endpackage

// File: rtl/fdly_compare.sv
// Module fdly_compare
// Purpose: compares the FIFO level with the threshold and with the low-water
//          mark (threshold minus HYST); pure combinational.
// Assumes: rx_level is an unsigned count; hold_thr is unsigned.
module fdly_compare
    import rts_pkg::*;
#(
    parameter int LVL_W = 7
) (
    input  logic [LVL_W-1:0] rx_level,
    input  logic [THR_W-1:0] hold_thr,
    output hold_cmp_t        cmp
);
    localparam int CMP_W = ((LVL_W > THR_W) ? LVL_W : THR_W) + 1;

    logic [CMP_W-1:0] lvl_x;
    logic [CMP_W-1:0] thr_x;
    logic [CMP_W-1:0] low_x;

    // Widen operands so that no comparison wraps
    always_comb begin
        lvl_x = CMP_W'(rx_level);
        thr_x = CMP_W'(hold_thr);
        low_x = thr_x - CMP_W'(HYST);
    end

    // Derive the three comparison flags
    always_comb begin
        cmp.enabled = (thr_x >= CMP_W'(MIN_THR));
        cmp.reach   = (lvl_x >= thr_x);
        cmp.drained = cmp.enabled && (lvl_x <= low_x);
    end
endmodule

// File: rtl/fdly_trigger.sv
// Module fdly_trigger
// Purpose: holds the flow-delay trigger flag with hysteresis.
// Assumes: cmp comes from fdly_compare in the same cycle; sync active-low reset.
module fdly_trigger
    import rts_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  hold_cmp_t cmp,
    output logic      trig_d,
    output logic      trig_q
);
    // Next-state rule: disable wins, then set, then release, else hold
    always_comb begin
        if (!cmp.enabled)      trig_d = 1'b0;
        else if (cmp.reach)    trig_d = 1'b1;
        else if (cmp.drained)  trig_d = 1'b0;
        else                   trig_d = trig_q;
    end

    // Trigger register
    always_ff @(posedge clk) begin
        if (!rst_n) trig_q <= 1'b0;
        else        trig_q <= trig_d;
    end

    // R1: reaching the threshold sets the flag
    a_r1_set_on_reach: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp.enabled && cmp.reach) |=> trig_q);
    // R4: flag held inside the band
    a_r4_hold_in_band: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_q && cmp.enabled && !cmp.drained) |=> trig_q);
    // R4: release once drained
    a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
        cmp.drained |=> !trig_q);
    // R5: small threshold keeps the flag clear
    a_r5_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp.enabled |=> !trig_q);
    // R7: no set from below the threshold
    a_r7_no_false_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_q && !cmp.reach) |=> !trig_q);
endmodule

// File: rtl/rts_drive.sv
// Module rts_drive
// Purpose: registers the active-low RTS pin from either the trigger or software.
// Assumes: trig_d is the trigger's next state, so pin and flag move together.
module rts_drive (
    input  logic clk,
    input  logic rst_n,
    input  logic fc_mode,
    input  logic sw_rts,
    input  logic trig_d,
    output logic rts_n
);
    logic pin_d;

    // Select the source for the pin
    always_comb begin
        pin_d = fc_mode ? trig_d : ~sw_rts;
    end

    // Pin register, deasserted (high) in reset
    always_ff @(posedge clk) begin
        if (!rst_n) rts_n <= 1'b1;
        else        rts_n <= pin_d;
    end

    // R6: software bit drives the pin when flow control is off
    a_r6_sw_follow: assert property (@(posedge clk) disable iff (!rst_n)
        !fc_mode |=> (rts_n == !$past(sw_rts)));
endmodule

// File: rtl/rx_flow_rts_ctrl.sv
// Module rx_flow_rts_ctrl
// Purpose: top of the flow-delay RTS controller; compares the level, keeps the
//          hysteretic trigger and drives the active-low RTS pin.
// Assumes: inputs are synchronous to clk; level fits in LVL_W bits.
module rx_flow_rts_ctrl
    import rts_pkg::*;
#(
    parameter int LVL_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [THR_W-1:0] hold_thr,
    input  logic             fc_mode,
    input  logic             sw_rts,
    output logic             rts_n,
    output logic             hold_active
);
    hold_cmp_t cmp;
    logic      trig_d;
    logic      trig_q;

    fdly_compare #(.LVL_W(LVL_W)) u_cmp (
        .rx_level (rx_level),
        .hold_thr (hold_thr),
        .cmp      (cmp)
    );

    fdly_trigger u_trig (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmp    (cmp),
        .trig_d (trig_d),
        .trig_q (trig_q)
    );

    rts_drive u_drv (
        .clk     (clk),
        .rst_n   (rst_n),
        .fc_mode (fc_mode),
        .sw_rts  (sw_rts),
        .trig_d  (trig_d),
        .rts_n   (rts_n)
    );

    // Status output is the trigger flag
    always_comb hold_active = trig_q;

    // R3: in flow-control mode the pin mirrors the trigger
    a_r3_pin_mirrors: assert property (@(posedge clk) disable iff (!rst_n)
        fc_mode |=> (rts_n == hold_active));
    // R2: reset state of both outputs
    a_r2_reset_state: assert property (@(posedge clk)
        !rst_n |=> (rts_n && !hold_active));
endmodule

// File: tb/test_rx_flow_rts_ctrl.sv
module test_rx_flow_rts_ctrl;
    localparam int LVL_W = 7;
    localparam int NV    = 20;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [LVL_W-1:0] rx_level;
    logic [5:0]       hold_thr;
    logic             fc_mode;
    logic             sw_rts;
    logic             rts_n;
    logic             hold_active;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    rx_flow_rts_ctrl #(.LVL_W(LVL_W)) i_rx_flow_rts_ctrl (
        .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .hold_thr(hold_thr),
        .fc_mode(fc_mode), .sw_rts(sw_rts), .rts_n(rts_n), .hold_active(hold_active)
    );

    // {thr, level, fc_mode, sw_rts, expected hold_active, expected rts_n}
    localparam logic [16:0] VEC [NV] = '{
        {6'd10, 7'd0,  1'b1, 1'b0, 1'b0, 1'b0},  // R3 idle, pin asserted
        {6'd10, 7'd9,  1'b1, 1'b0, 1'b0, 1'b0},  // R7 just below
        {6'd10, 7'd10, 1'b1, 1'b0, 1'b1, 1'b1},  // R1 reach
        {6'd10, 7'd7,  1'b1, 1'b0, 1'b1, 1'b1},  // R4 hold in band
        {6'd10, 7'd12, 1'b1, 1'b0, 1'b1, 1'b1},  // R1 above
        {6'd10, 7'd6,  1'b1, 1'b0, 1'b0, 1'b0},  // R4 release at thr-4
        {6'd10, 7'd9,  1'b1, 1'b0, 1'b0, 1'b0},  // R7 band from below
        {6'd10, 7'd10, 1'b1, 1'b0, 1'b1, 1'b1},  // R1 again
        {6'd10, 7'd10, 1'b0, 1'b1, 1'b1, 1'b0},  // R6 sw=1 -> low
        {6'd10, 7'd10, 1'b0, 1'b0, 1'b1, 1'b1},  // R6 sw=0 -> high
        {6'd3,  7'd10, 1'b1, 1'b0, 1'b0, 1'b0},  // R5 disable while active
        {6'd3,  7'd3,  1'b1, 1'b0, 1'b0, 1'b0},  // R5 level = thr
        {6'd4,  7'd4,  1'b1, 1'b0, 1'b1, 1'b1},  // R1 minimum threshold
        {6'd4,  7'd1,  1'b1, 1'b0, 1'b1, 1'b1},  // R4 band down to 1
        {6'd4,  7'd0,  1'b1, 1'b0, 1'b0, 1'b0},  // R4 release at 0
        {6'd63, 7'd63, 1'b1, 1'b0, 1'b1, 1'b1},  // R1 max threshold
        {6'd63, 7'd59, 1'b1, 1'b0, 1'b0, 1'b0},  // R4 release at 59
        {6'd10, 7'd64, 1'b1, 1'b0, 1'b1, 1'b1},  // R1 full FIFO
        {6'd0,  7'd64, 1'b1, 1'b0, 1'b0, 1'b0},  // R5 zero threshold
        {6'd0,  7'd64, 1'b0, 1'b1, 1'b0, 1'b0}   // R6 with hold disabled
    };

    task automatic check(input string req, input logic exp_h, input logic exp_p);
        n_cmp++;
        if (hold_active !== exp_h || rts_n !== exp_p) begin
            n_bad++;
            $display("FAIL %s: hold_active=%b rts_n=%b expected hold_active=%b rts_n=%b",
                     req, hold_active, rts_n, exp_h, exp_p);
        end
    endtask

    initial begin
        rst_n = 1'b0; rx_level = '0; hold_thr = 6'd10; fc_mode = 1'b1; sw_rts = 1'b0;
        repeat (3) @(negedge clk);
        check("R2 reset", 1'b0, 1'b1);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            hold_thr = VEC[i][16:11];
            rx_level = VEC[i][10:4];
            fc_mode  = VEC[i][3];
            sw_rts   = VEC[i][2];
            @(negedge clk);
            check($sformatf("vector %0d (R1/R3/R4/R5/R6/R7)", i), VEC[i][1], VEC[i][0]);
        end

        // R2: reset while holding clears both outputs
        hold_thr = 6'd8; rx_level = 7'd20; fc_mode = 1'b1;
        @(negedge clk);
        check("R1 pre-reset", 1'b1, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R2 reset while holding", 1'b0, 1'b1);
        rst_n = 1'b1; rx_level = 7'd5;
        @(negedge clk);
        check("R7 band after reset", 1'b0, 1'b0);
        rx_level = 7'd4;
        @(negedge clk);
        check("R4 drained after reset", 1'b0, 1'b0);

        // R6: pin follows software across toggles
        fc_mode = 1'b0;
        for (int k = 0; k < 4; k++) begin
            sw_rts = k[0];
            @(negedge clk);
            check("R6 toggle", 1'b0, ~k[0]);
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (2000) @(posedge clk);
                n_cmp++; n_bad++;
                $display("FAIL watchdog: run hung, expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule